// File: doc/BRIEF.md
# ALU Status Flag Unit

This block keeps the processor's 8-bit status byte. After each arithmetic or logic operation, it takes in the operation kind, both operands, the result the datapath produced and the carry-in. From these it works out the half-carry, sign, overflow, negative, zero and carry flags. It also holds two flags that software controls directly. The first is an interrupt-enable bit, changed only by explicit set and clear strobes. The second is a bit-copy flag, loaded from one selected bit of a register word by a bit-store strobe. A bit-load reads that flag back through the status output.

All updates are registered. The status byte seen at the output reflects every command that was presented before the most recent rising clock edge. Commands that touch different bits may be issued in the same cycle and do not disturb each other.

Top module: `alu_status_flags`

## Requirements
- R1: While rst_n is low, and on the first rising edge after it goes low, status becomes 0x00.
- R2: Bit 7 (interrupt enable) is set by ie_set and cleared by ie_clr. Clear wins when both are high. Bit 7 changes for no other input.
- R3: When bst_en is high, bit 6 (bit-copy flag) takes bst_src[bst_sel]. Otherwise it keeps its value, and ALU operations never change it.
- R4: Bit 0 (carry) is the carry out of bit 7 of a+b+cin for add kinds. For subtract kinds it is set when b+cin exceeds a as unsigned numbers. cin is carry_in for ADC and SBC and is taken as 0 for ADD and SUB.
- R5: Bit 5 (half carry) is the same carry or borrow worked out on the low nibbles only, so it marks a carry or borrow out of bit 3.
- R6: Bit 3 (overflow) is (a7&b7&~r7)|(~a7&~b7&r7) for add kinds and (a7&~b7&~r7)|(~a7&b7&r7) for subtract kinds. Bit 2 (negative) is r7.
- R7: Bit 1 (zero) is set when the result is 0x00 for ADD, ADC, SUB and LOGIC. For SBC it is set only when the result is 0x00 and bit 1 was already set.
- R8: Bit 4 (sign) is always equal to bit 2 XOR bit 3.
- R9: A LOGIC operation clears overflow, updates negative, zero and sign, and leaves carry and half carry unchanged.
- R10: op_kind codes are 0 ADD, 1 ADC, 2 SUB, 3 SBC and 4 LOGIC. With op_valid low, or with codes 5 to 7, bits 5:0 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An ALU operation is being reported this cycle |
| op_kind | input | 3 | Operation kind (0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 LOGIC) |
| opnd_a | input | 8 | First operand (minuend for subtract) |
| opnd_b | input | 8 | Second operand (subtrahend for subtract) |
| alu_res | input | 8 | Result produced by the datapath |
| carry_in | input | 1 | Carry or borrow into the operation |
| ie_set | input | 1 | Set the interrupt-enable bit |
| ie_clr | input | 1 | Clear the interrupt-enable bit |
| bst_en | input | 1 | Copy a register bit into the bit-copy flag |
| bst_src | input | 8 | Register word that holds the bit to copy |
| bst_sel | input | 3 | Index of the bit to copy |
| status | output | 8 | Status byte {I,T,H,S,V,N,Z,C} |

## Verification
Each command shows on status after exactly one rising edge. The bench therefore drives every stimulus on a falling edge and reads status on the next falling edge, after that one capture edge has passed. The vector table is walked in order on purpose. The expected carry and half-carry after a LOGIC step, and the expected zero after an SBC step, depend on the flags left by the step before. Directed tests then check that ignored commands leave the byte unchanged when it is read one cycle later.

// File: rtl/alu_status_flags.sv
module alu_status_flags #(
  parameter int DW = 8,
  localparam int SW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_kind,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [DW-1:0] alu_res,
  input  logic          carry_in,
  input  logic          ie_set,
  input  logic          ie_clr,
  input  logic          bst_en,
  input  logic [DW-1:0] bst_src,
  input  logic [SW-1:0] bst_sel,
  output logic [7:0]    status
);
  localparam int MSB = DW - 1;
  localparam int NW = 4;

  typedef enum logic [2:0] {
    K_ADD = 3'd0, K_ADC = 3'd1, K_SUB = 3'd2, K_SBC = 3'd3, K_LOGIC = 3'd4
  } op_kind_t;

  logic ie_q, tc_q, hc_q, sg_q, ov_q, ng_q, zr_q, cy_q;

  wire is_add = (op_kind == K_ADD) || (op_kind == K_ADC);
  wire is_sub = (op_kind == K_SUB) || (op_kind == K_SBC);
  wire is_log = (op_kind == K_LOGIC);
  wire upd    = op_valid && (is_add || is_sub || is_log);
  wire cin    = carry_in && ((op_kind == K_ADC) || (op_kind == K_SBC));

  wire [DW:0] full_sum = {1'b0, opnd_a} + {1'b0, opnd_b} + {{DW{1'b0}}, cin};
  wire [DW:0] sub_rhs  = {1'b0, opnd_b} + {{DW{1'b0}}, cin};
  wire [NW:0] nib_sum  = {1'b0, opnd_a[NW-1:0]} + {1'b0, opnd_b[NW-1:0]} + {{NW{1'b0}}, cin};
  wire [NW:0] nib_rhs  = {1'b0, opnd_b[NW-1:0]} + {{NW{1'b0}}, cin};

  wire cy_add = full_sum[DW];
  wire cy_sub = sub_rhs > {1'b0, opnd_a};
  wire hc_add = nib_sum[NW];
  wire hc_sub = nib_rhs > {1'b0, opnd_a[NW-1:0]};

  wire a7 = opnd_a[MSB];
  wire b7 = opnd_b[MSB];
  wire r7 = alu_res[MSB];
  wire ov_add = (a7 & b7 & ~r7) | (~a7 & ~b7 & r7);
  wire ov_sub = (a7 & ~b7 & ~r7) | (~a7 & b7 & r7);
  wire res_zero = (alu_res == '0);

  logic hc_d, ov_d, zr_d, cy_d;

  always_comb begin
    hc_d = hc_q;
    cy_d = cy_q;
    ov_d = 1'b0;
    zr_d = res_zero;
    if (is_add) begin
      hc_d = hc_add;
      cy_d = cy_add;
      ov_d = ov_add;
    end else if (is_sub) begin
      hc_d = hc_sub;
      cy_d = cy_sub;
      ov_d = ov_sub;
      if (op_kind == K_SBC) zr_d = res_zero & zr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {ie_q, tc_q, hc_q, sg_q, ov_q, ng_q, zr_q, cy_q} <= 8'h00;
    end else begin
      if (ie_clr)      ie_q <= 1'b0;
      else if (ie_set) ie_q <= 1'b1;
      if (bst_en) tc_q <= bst_src[bst_sel];
      if (upd) begin
        hc_q <= hc_d;
        cy_q <= cy_d;
        ov_q <= ov_d;
        ng_q <= r7;
        zr_q <= zr_d;
        sg_q <= r7 ^ ov_d;
      end
    end
  end

  assign status = {ie_q, tc_q, hc_q, sg_q, ov_q, ng_q, zr_q, cy_q};
endmodule

// File: rtl/alu_status_flags_chk.sv
module alu_status_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [2:0] op_kind,
  input logic [7:0] alu_res,
  input logic       ie_set,
  input logic       ie_clr,
  input logic       bst_en,
  input logic [7:0] status
);
  p_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] == (status[2] ^ status[3]));

  p_ie_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_set && !ie_clr) |=> $stable(status[7]));

  p_ie_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ie_clr |=> !status[7]);

  p_tc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bst_en |=> $stable(status[6]));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_kind > 3'd4) |=> $stable(status[5:0]));

  p_logic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd4) |=>
      (!status[3] && $stable(status[0]) && $stable(status[5])));

  p_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind <= 3'd4) |=> status[2] == $past(alu_res[7]));

  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind <= 3'd4 && op_kind != 3'd3) |=>
      status[1] == ($past(alu_res) == 8'h00));
endmodule

bind alu_status_flags alu_status_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .alu_res(alu_res), .ie_set(ie_set), .ie_clr(ie_clr), .bst_en(bst_en),
  .status(status)
);

// File: tb/alu_status_flags_tb.sv
module alu_status_flags_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_kind = 3'd0;
  logic [7:0] opnd_a = 8'h00, opnd_b = 8'h00, alu_res = 8'h00;
  logic       carry_in = 1'b0;
  logic       ie_set = 1'b0, ie_clr = 1'b0, bst_en = 1'b0;
  logic [7:0] bst_src = 8'h00;
  logic [2:0] bst_sel = 3'd0;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_status_flags u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_res(alu_res), .carry_in(carry_in),
    .ie_set(ie_set), .ie_clr(ie_clr), .bst_en(bst_en), .bst_src(bst_src),
    .bst_sel(bst_sel), .status(status)
  );

  // {kind[3], a[8], b[8], cin, expected {H,S,V,N,Z,C}}
  localparam int NV = 15;
  localparam logic [25:0] VEC [NV] = '{
    {3'd0, 8'h0F, 8'h01, 1'b0, 6'b100000},
    {3'd0, 8'h7F, 8'h01, 1'b0, 6'b101100},
    {3'd0, 8'hFF, 8'h01, 1'b0, 6'b100011},
    {3'd1, 8'h80, 8'h80, 1'b1, 6'b011001},
    {3'd4, 8'hF0, 8'h0F, 1'b0, 6'b000011},
    {3'd2, 8'h10, 8'h01, 1'b0, 6'b100000},
    {3'd2, 8'h80, 8'h01, 1'b0, 6'b111000},
    {3'd2, 8'h01, 8'h02, 1'b0, 6'b110101},
    {3'd2, 8'h05, 8'h05, 1'b1, 6'b000010},
    {3'd3, 8'h00, 8'h00, 1'b0, 6'b000010},
    {3'd3, 8'h00, 8'h00, 1'b1, 6'b110101},
    {3'd3, 8'h01, 8'h00, 1'b1, 6'b000000},
    {3'd4, 8'h80, 8'hFF, 1'b0, 6'b010100},
    {3'd0, 8'h08, 8'h08, 1'b1, 6'b100000},
    {3'd4, 8'h81, 8'hFF, 1'b0, 6'b110100}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: status=%02h expected=%02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] calc_res(input logic [2:0] k, input logic [7:0] a,
                                          input logic [7:0] b, input logic c);
    case (k)
      3'd0:    return a + b;
      3'd1:    return a + b + {7'd0, c};
      3'd2:    return a - b;
      3'd3:    return a - b - {7'd0, c};
      default: return a & b;
    endcase
  endfunction

  task automatic idle();
    op_valid = 1'b0; ie_set = 1'b0; ie_clr = 1'b0; bst_en = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] k, input logic [7:0] a, input logic [7:0] b,
                        input logic c);
    @(negedge clk);
    idle();
    op_valid = 1'b1; op_kind = k; opnd_a = a; opnd_b = b; carry_in = c;
    alu_res = calc_res(k, a, b, c);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: status=%02h expected=completion", status);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", status, 8'h00);
    rst_n = 1'b1;

    // R4 R5 R6 R7 R8 R9: flag vectors walked in order
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][25:23], VEC[i][22:15], VEC[i][14:7], VEC[i][6]);
      check($sformatf("R4/R5/R6/R7/R8/R9 vector %0d", i), status, {2'b00, VEC[i][5:0]});
    end

    // R10: reserved kinds and op_valid low keep flags (current 0x34)
    for (int k = 5; k < 8; k++) begin
      run_op(3'(k), 8'hFF, 8'h01, 1'b1);
      check($sformatf("R10 reserved kind %0d", k), status, 8'h34);
    end
    @(negedge clk);
    op_valid = 1'b0; op_kind = 3'd0; opnd_a = 8'hFF; opnd_b = 8'h01; alu_res = 8'h00;
    @(negedge clk);
    check("R10 op_valid low", status, 8'h34);

    // R2: interrupt enable set, clear, clear wins
    @(negedge clk); ie_set = 1'b1;
    @(negedge clk); idle();
    check("R2 set", status, 8'hB4);
    @(negedge clk); ie_set = 1'b1; ie_clr = 1'b1;
    @(negedge clk); idle();
    check("R2 clear wins", status, 8'h34);
    @(negedge clk); ie_set = 1'b1;
    @(negedge clk); idle(); ie_clr = 1'b1;
    @(negedge clk); idle();
    check("R2 clear", status, 8'h34);

    // R3: bit-store copies selected bit
    @(negedge clk); bst_en = 1'b1; bst_src = 8'h20; bst_sel = 3'd5;
    @(negedge clk); idle();
    check("R3 store one", status, 8'h74);
    @(negedge clk); bst_en = 1'b1; bst_src = 8'hDF; bst_sel = 3'd5;
    @(negedge clk); idle();
    check("R3 store zero", status, 8'h34);
    @(negedge clk); bst_en = 1'b1; bst_src = 8'h01; bst_sel = 3'd0;
    @(negedge clk); idle(); ie_set = 1'b1;
    @(negedge clk); idle();
    check("R3 store bit0 and R2 set", status, 8'hF4);

    // R2 R3: ALU op leaves I and T alone; bst_src changes without bst_en ignored
    bst_src = 8'h00;
    run_op(3'd0, 8'h01, 8'h01, 1'b0);
    check("R2/R3 untouched by ALU op", status, 8'hC0);

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", status, 8'h00);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule